// File: doc/BRIEF.md
# Ring-Oscillator Pair Frequency Comparator

This block turns a bank of free-running ring-oscillator signals into a multi-bit response word. Each challenge names two oscillator rows and a crossing configuration. The configuration is presented on an output so that the oscillator fabric can route its inverter stages. The two chosen oscillators each drive a saturating edge counter. Both counters run over the same window, a fixed number of system-clock cycles long. The counts are then compared and give one response bit.

A short list of challenges is supplied as one flat vector. After a start strobe the block works through the list in order. It measures one pair per entry, shifts each bit into a response register and raises a single-cycle done strobe at the end. Every oscillator input first passes through a two-flop synchroniser and a rising-edge detector, so the oscillators may run asynchronously to the system clock. They must stay below half its rate.

Top module: `ro_pair_compare`

## Requirements
- R1: While reset is high and in the cycle after it, the counts, the response bit, the tie flag, the bit strobe, the response word and the done strobe are all zero, and `cross_cfg_o` shows the configuration field of list entry 0.
- R2: List entry j occupies `chal_list_i[j*ENT_W +: ENT_W]`. Within an entry, bits [SEL_W-1:0] select the row for counter B, bits [2*SEL_W-1:SEL_W] select the row for counter A, and the top CFG_W bits are the crossing configuration. `cross_cfg_o` shows the configuration of the entry currently in use.
- R3: A rising level on an oscillator input that is first seen at clock edge k adds one to a counter at edge k+2, provided that edge is a counting edge for the row that counter has selected.
- R4: A start seen at edge s while idle opens the window for bit j on edges s+1+j*(WIN_CYC+1) through s+WIN_CYC+j*(WIN_CYC+1). The decision for bit j is taken at edge s+(j+1)*(WIN_CYC+1).
- R5: Both counts are cleared on an accepted start. Each window's first counting edge loads the counter with that edge's increment. The counts stay frozen from the window's end until the next window's first counting edge.
- R6: A count that reaches 2^CNT_W-1 stays there for the rest of its window.
- R7: At each decision, `resp_bit_o` becomes 1 when count A exceeds count B and 0 otherwise. `tie_o` becomes 1 exactly when the counts are equal. Both hold until the next decision, and `bit_valid_o` is high for that one cycle.
- R8: An accepted start clears `key_o`. Each decision shifts the word right and puts the new bit at index LIST_LEN-1, so after a full run `key_o[j]` holds the bit of entry j.
- R9: `done_o` is high for exactly one cycle, at the edge after the last decision. The entry index then returns to 0, and a start in that cycle is accepted.
- R10: A start seen while a run is in progress, or on the edge that raises `done_o`, is ignored: timing, counts and the response word follow the first run only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ro_i | input | NUM_RO | Raw oscillator signals, one per row |
| start_i | input | 1 | Start strobe for a run through the list |
| chal_list_i | input | LIST_LEN*ENT_W | Flat challenge list, held during a run |
| cross_cfg_o | output | CFG_W | Crossing configuration of the current entry |
| cnt_a_o | output | CNT_W | Count of the row chosen for counter A |
| cnt_b_o | output | CNT_W | Count of the row chosen for counter B |
| resp_bit_o | output | 1 | Latest response bit |
| tie_o | output | 1 | Latest decision had equal counts |
| bit_valid_o | output | 1 | One-cycle strobe for each decision |
| key_o | output | LIST_LEN | Response word, bit 0 from the first entry |
| done_o | output | 1 | One-cycle strobe at the end of a run |

## Verification
The bench drives oscillators whose half-periods depend on the row and on the configuration the block presents. Three lists are used. The first has distinct rows with different rates, so the bit direction depends on which row is faster. The second holds only corner entries: two stuck rows, two saturated rows, the same row on both sides, and saturated against stuck. This separates tie handling from the greater-than path and shows clamping. The third list starts in the same cycle as the previous done strobe and receives extra start pulses mid-run and in the done-raising cycle. This separates back-to-back acceptance from wrongly accepted restarts.

// File: rtl/ro_cmp_pkg.sv
package ro_cmp_pkg;

    localparam int DEF_NUM_RO   = 8;
    localparam int DEF_CNT_W    = 7;
    localparam int DEF_WIN_CYC  = 64;
    localparam int DEF_LIST_LEN = 4;
    localparam int DEF_CFG_W    = 4;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_COUNT  = 2'd1,
        SQ_DECIDE = 2'd2,
        SQ_FINISH = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic one;
        logic tie;
    } verdict_t;

    function automatic verdict_t judge(input logic [31:0] cnt_a, input logic [31:0] cnt_b);
        verdict_t v;
        v.one = (cnt_a > cnt_b);
        v.tie = (cnt_a == cnt_b);
        return v;
    endfunction

endpackage

// File: rtl/ro_edge_sync.sv
module ro_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic meta_q;
    logic stable_q;
    logic last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= 1'b0;
            stable_q <= 1'b0;
            last_q   <= 1'b0;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
            last_q   <= stable_q;
        end
    end

    assign rise_o = stable_q & ~last_q;
endmodule

// File: rtl/ro_win_counter.sv
module ro_win_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             en_i,
    input  logic             load_i,
    input  logic             pulse_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt_o <= '0;
        end else if (en_i) begin
            if (load_i) begin
                cnt_o <= {{(CNT_W-1){1'b0}}, pulse_i};
            end else if (pulse_i && cnt_o != CNT_MAX) begin
                cnt_o <= cnt_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ro_seq_ctrl.sv
module ro_seq_ctrl
    import ro_cmp_pkg::*;
#(
    parameter int WIN_CYC  = 64,
    parameter int LIST_LEN = 4,
    localparam int TICK_W  = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1,
    localparam int IDX_W   = (LIST_LEN > 1) ? $clog2(LIST_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             clear_o,
    output logic             cnt_en_o,
    output logic             cnt_load_o,
    output logic             decide_o,
    output logic             done_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(WIN_CYC - 1);
    localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(LIST_LEN - 1);

    seq_state_e        state_q;
    logic [TICK_W-1:0] tick_q;

    assign clear_o    = (state_q == SQ_IDLE) && start_i;
    assign cnt_en_o   = (state_q == SQ_COUNT);
    assign cnt_load_o = (tick_q == '0);
    assign decide_o   = (state_q == SQ_DECIDE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            tick_q  <= '0;
            idx_o   <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                SQ_IDLE: begin
                    if (start_i) begin
                        state_q <= SQ_COUNT;
                        tick_q  <= '0;
                        idx_o   <= '0;
                    end
                end
                SQ_COUNT: begin
                    if (tick_q == TICK_LAST) begin
                        state_q <= SQ_DECIDE;
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                SQ_DECIDE: begin
                    tick_q <= '0;
                    if (idx_o == IDX_LAST) begin
                        state_q <= SQ_FINISH;
                    end else begin
                        idx_o   <= idx_o + 1'b1;
                        state_q <= SQ_COUNT;
                    end
                end
                SQ_FINISH: begin
                    done_o  <= 1'b1;
                    idx_o   <= '0;
                    state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ro_pair_compare.sv
module ro_pair_compare
    import ro_cmp_pkg::*;
#(
    parameter int NUM_RO   = DEF_NUM_RO,
    parameter int CNT_W    = DEF_CNT_W,
    parameter int WIN_CYC  = DEF_WIN_CYC,
    parameter int LIST_LEN = DEF_LIST_LEN,
    parameter int CFG_W    = DEF_CFG_W,
    localparam int SEL_W   = (NUM_RO > 1) ? $clog2(NUM_RO) : 1,
    localparam int ENT_W   = CFG_W + 2 * SEL_W,
    localparam int IDX_W   = (LIST_LEN > 1) ? $clog2(LIST_LEN) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_RO-1:0]         ro_i,
    input  logic                      start_i,
    input  logic [LIST_LEN*ENT_W-1:0] chal_list_i,
    output logic [CFG_W-1:0]          cross_cfg_o,
    output logic [CNT_W-1:0]          cnt_a_o,
    output logic [CNT_W-1:0]          cnt_b_o,
    output logic                      resp_bit_o,
    output logic                      tie_o,
    output logic                      bit_valid_o,
    output logic [LIST_LEN-1:0]       key_o,
    output logic                      done_o
);
    logic [NUM_RO-1:0] rise;
    logic              clear;
    logic              cnt_en;
    logic              cnt_load;
    logic              decide;
    logic [IDX_W-1:0]  idx;
    logic [ENT_W-1:0]  cur_ent;
    logic [SEL_W-1:0]  sel [2];
    logic              pair_pulse [2];
    logic [CNT_W-1:0]  pair_cnt [2];
    verdict_t          verdict;
    logic [LIST_LEN-1:0] key_next;

    // Edge detection on every row ahead of the selection.
    for (genvar r = 0; r < NUM_RO; r++) begin : g_sync
        ro_edge_sync u_sync (
            .clk     (clk),
            .rst     (rst),
            .async_i (ro_i[r]),
            .rise_o  (rise[r])
        );
    end

    ro_seq_ctrl #(
        .WIN_CYC  (WIN_CYC),
        .LIST_LEN (LIST_LEN)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .clear_o    (clear),
        .cnt_en_o   (cnt_en),
        .cnt_load_o (cnt_load),
        .decide_o   (decide),
        .done_o     (done_o),
        .idx_o      (idx)
    );

    assign cur_ent     = chal_list_i[idx*ENT_W +: ENT_W];
    assign sel[0]      = cur_ent[2*SEL_W-1:SEL_W];
    assign sel[1]      = cur_ent[SEL_W-1:0];
    assign cross_cfg_o = cur_ent[ENT_W-1:2*SEL_W];

    for (genvar p = 0; p < 2; p++) begin : g_pair
        assign pair_pulse[p] = rise[sel[p]];
        ro_win_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .clear_i (clear),
            .en_i    (cnt_en),
            .load_i  (cnt_load),
            .pulse_i (pair_pulse[p]),
            .cnt_o   (pair_cnt[p])
        );
    end

    assign cnt_a_o = pair_cnt[0];
    assign cnt_b_o = pair_cnt[1];
    assign verdict = judge(32'(pair_cnt[0]), 32'(pair_cnt[1]));

    always_comb begin
        key_next = key_o >> 1;
        key_next[LIST_LEN-1] = verdict.one;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_bit_o  <= 1'b0;
            tie_o       <= 1'b0;
            bit_valid_o <= 1'b0;
            key_o       <= '0;
        end else begin
            bit_valid_o <= decide;
            if (clear) begin
                key_o <= '0;
            end else if (decide) begin
                resp_bit_o <= verdict.one;
                tie_o      <= verdict.tie;
                key_o      <= key_next;
            end
        end
    end
endmodule

// File: rtl/ro_pair_compare_chk.sv
module ro_pair_compare_chk #(
    parameter int WIN_CYC = 64,
    parameter int CNT_W   = 7
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt_a_o,
    input logic [CNT_W-1:0] cnt_b_o,
    input logic             resp_bit_o,
    input logic             tie_o,
    input logic             bit_valid_o,
    input logic             done_o
);
    int   gap_q;
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q   <= 0;
            armed_q <= 1'b0;
        end else if (bit_valid_o) begin
            gap_q   <= 0;
            armed_q <= 1'b1;
        end else begin
            if (done_o) armed_q <= 1'b0;
            if (gap_q < WIN_CYC + 4) gap_q <= gap_q + 1;
        end
    end

    assert_one_if_greater_R7: assert property (@(posedge clk) disable iff (rst)
        (bit_valid_o && resp_bit_o) |-> (cnt_a_o > cnt_b_o));
    assert_zero_if_not_greater_R7: assert property (@(posedge clk) disable iff (rst)
        (bit_valid_o && !resp_bit_o) |-> (cnt_a_o <= cnt_b_o));
    assert_tie_matches_R7: assert property (@(posedge clk) disable iff (rst)
        bit_valid_o |-> (tie_o == (cnt_a_o == cnt_b_o)));
    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
        bit_valid_o |=> !bit_valid_o);
    assert_counts_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        bit_valid_o |-> ($stable(cnt_a_o) && $stable(cnt_b_o)));
    assert_window_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        (bit_valid_o && armed_q) |-> (gap_q == WIN_CYC));
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    assert_done_after_bit_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(bit_valid_o));
endmodule

bind ro_pair_compare ro_pair_compare_chk #(
    .WIN_CYC (WIN_CYC),
    .CNT_W   (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cnt_a_o     (cnt_a_o),
    .cnt_b_o     (cnt_b_o),
    .resp_bit_o  (resp_bit_o),
    .tie_o       (tie_o),
    .bit_valid_o (bit_valid_o),
    .done_o      (done_o)
);

// File: tb/test_ro_pair_compare.sv
`timescale 1ns/1ps
module test_ro_pair_compare;
    localparam int NRO   = 8;
    localparam int CW    = 7;
    localparam int WIN   = 300;
    localparam int LL    = 4;
    localparam int CFGW  = 4;
    localparam int SW    = 3;
    localparam int EW    = CFGW + 2 * SW;
    localparam int CMAX  = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NRO-1:0] ro = '0;
    logic start = 1'b0;
    logic [LL*EW-1:0] chal_list = '0;
    logic [CFGW-1:0] cross_cfg;
    logic [CW-1:0] cnt_a, cnt_b;
    logic resp_bit, tie, bit_valid, done;
    logic [LL-1:0] key;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int done_seen = 0;

    always #2.5 clk = ~clk;

    ro_pair_compare #(
        .NUM_RO(NRO), .CNT_W(CW), .WIN_CYC(WIN), .LIST_LEN(LL), .CFG_W(CFGW)
    ) i_ro_pair_compare (
        .clk(clk), .rst(rst), .ro_i(ro), .start_i(start), .chal_list_i(chal_list),
        .cross_cfg_o(cross_cfg), .cnt_a_o(cnt_a), .cnt_b_o(cnt_b),
        .resp_bit_o(resp_bit), .tie_o(tie), .bit_valid_o(bit_valid),
        .key_o(key), .done_o(done)
    );

    function automatic logic [EW-1:0] ent(input int cfg, input int a, input int b);
        return {CFGW'(cfg), SW'(a), SW'(b)};
    endfunction

    // Row half-period in clock cycles; 0 = stuck low.
    function automatic int half_per(input int row, input int cfg);
        if (row == 7) return 0;
        if (row == 6) return 1;
        return 2 + ((row * 5 + cfg) % 7);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Behavioural oscillators.
    int phase [NRO];
    always @(negedge clk) begin
        for (int r = 0; r < NRO; r++) begin
            int hp;
            hp = half_per(r, int'(cross_cfg));
            if (hp == 0) begin
                ro[r] <= 1'b0;
            end else begin
                phase[r]++;
                if (phase[r] >= hp) begin
                    phase[r] = 0;
                    ro[r] <= ~ro[r];
                end
            end
        end
    end

    // Reference model, advanced at each rising edge.
    logic [NRO-1:0] hist [$];
    int m_st = 0, m_tick = 0, m_idx = 0, m_ca = 0, m_cb = 0;
    logic m_bit = 0, m_tie = 0, m_valid = 0, m_done = 0;
    logic [LL-1:0] m_key = '0;

    always @(posedge clk) begin
        logic [NRO-1:0] pulse;
        logic [EW-1:0] e;
        int pa, pb;
        if (rst) begin
            hist = {};
            for (int i = 0; i < 3; i++) hist.push_back('0);
            m_st = 0; m_tick = 0; m_idx = 0; m_ca = 0; m_cb = 0;
            m_bit = 0; m_tie = 0; m_valid = 0; m_done = 0; m_key = '0;
        end else begin
            pulse = hist[1] & ~hist[0];
            hist.push_back(ro);
            void'(hist.pop_front());
            e = chal_list[m_idx*EW +: EW];
            pa = int'(pulse[e[2*SW-1:SW]]);
            pb = int'(pulse[e[SW-1:0]]);
            m_valid = 0;
            m_done = 0;
            case (m_st)
                0: if (start) begin
                    m_st = 1; m_tick = 0; m_idx = 0; m_ca = 0; m_cb = 0; m_key = '0;
                end
                1: begin
                    if (m_tick == 0) begin m_ca = pa; m_cb = pb; end
                    else begin
                        m_ca = (m_ca + pa > CMAX) ? CMAX : m_ca + pa;
                        m_cb = (m_cb + pb > CMAX) ? CMAX : m_cb + pb;
                    end
                    m_tick++;
                    if (m_tick == WIN) m_st = 2;
                end
                2: begin
                    m_bit = (m_ca > m_cb);
                    m_tie = (m_ca == m_cb);
                    m_valid = 1;
                    m_key = {m_bit, m_key[LL-1:1]};
                    if (m_idx == LL - 1) m_st = 3;
                    else begin m_idx++; m_tick = 0; m_st = 1; end
                end
                default: begin m_done = 1; m_idx = 0; m_st = 0; end
            endcase
        end
    end

    // Cycle compare, 1 ns after the falling edge.
    int rec_a [LL], rec_b [LL], rec_n = 0;
    logic rec_bit [LL], rec_tie [LL];
    always @(negedge clk) begin
        logic [EW-1:0] e;
        #1;
        if (!rst) begin
            e = chal_list[m_idx*EW +: EW];
            chk(cnt_a == CW'(m_ca), "R2/R3/R5/R6 count A", int'(cnt_a), m_ca);
            chk(cnt_b == CW'(m_cb), "R2/R3/R5/R6 count B", int'(cnt_b), m_cb);
            chk(bit_valid == m_valid, "R4 bit strobe", int'(bit_valid), int'(m_valid));
            chk(resp_bit == m_bit, "R7 response bit", int'(resp_bit), int'(m_bit));
            chk(tie == m_tie, "R7 tie flag", int'(tie), int'(m_tie));
            chk(key == m_key, "R8 response word", int'(key), int'(m_key));
            chk(done == m_done, "R9/R10 done strobe", int'(done), int'(m_done));
            chk(cross_cfg == e[EW-1:2*SW], "R2 crossing config", int'(cross_cfg), int'(e[EW-1:2*SW]));
            if (done) done_seen++;
            if (bit_valid && rec_n < LL) begin
                rec_a[rec_n] = int'(cnt_a); rec_b[rec_n] = int'(cnt_b);
                rec_bit[rec_n] = resp_bit; rec_tie[rec_n] = tie; rec_n++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            chk(0, "watchdog", cyc, 100000);
            summary();
        end
    end

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    initial begin
        chal_list = {ent(9, 1, 0), ent(5, 4, 3), ent(3, 2, 5), ent(0, 0, 1)};
        repeat (4) @(negedge clk);
        #1;
        // R1 reset state
        chk(cnt_a == 0 && cnt_b == 0, "R1 counts in reset", int'(cnt_a) + int'(cnt_b), 0);
        chk(!resp_bit && !tie && !bit_valid && !done, "R1 flags in reset",
            int'({resp_bit, tie, bit_valid, done}), 0);
        chk(key == 0, "R1 word in reset", int'(key), 0);
        chk(cross_cfg == 4'd0, "R1 config of entry 0", int'(cross_cfg), 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // Run A: distinct rows.
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_done();

        // Run B: corner entries, hand-computed values.
        chal_list = {ent(0, 6, 7), ent(4, 3, 3), ent(1, 6, 6), ent(2, 7, 7)};
        rec_n = 0;
        repeat (2) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_done();
        #2;
        chk(rec_a[0] == 0 && rec_b[0] == 0 && rec_tie[0] && !rec_bit[0],
            "R7 stuck rows tie", rec_a[0] + rec_b[0], 0);
        chk(rec_a[1] == CMAX && rec_b[1] == CMAX, "R6 both saturate", rec_a[1], CMAX);
        chk(rec_tie[1] && !rec_bit[1], "R7 saturated tie", int'(rec_tie[1]), 1);
        chk(rec_a[2] == rec_b[2] && rec_tie[2] && !rec_bit[2], "R7 same row tie",
            rec_a[2] - rec_b[2], 0);
        chk(rec_a[3] == CMAX && rec_b[3] == 0 && rec_bit[3] && !rec_tie[3],
            "R6 R7 saturated beats stuck", rec_a[3], CMAX);
        chk(key == 4'b1000, "R8 word after corner run", int'(key), 8);

        // Run C: back-to-back start while done is high, extra starts ignored.
        chal_list = {ent(8, 0, 4), ent(15, 5, 1), ent(7, 2, 6), ent(7, 6, 2)};
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        chk(cnt_a != 0 || cnt_b != 0, "R9 back-to-back start accepted",
            int'(cnt_a) + int'(cnt_b), 1);
        repeat (50) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (700) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        // A start in the cycle before done rises must be ignored (R10).
        while (!(i_ro_pair_compare.bit_valid_o && m_st == 3)) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        #2;
        chk(done, "R10 done after ignored starts", int'(done), 1);
        repeat (4) @(negedge clk);
        chk(done_seen == 3, "R10 one done per accepted run", done_seen, 3);
        chk(cnt_a == CW'(m_ca) && !bit_valid, "R10 idle after run", int'(bit_valid), 0);
        summary();
    end
endmodule